// File: doc/BRIEF.md
# Snoop-Aware Bus Hold Arbiter

This block decides who drives a shared processor bus: the embedded CPU or a second bus master. It talks to the CPU through a hold request and hold acknowledge pair, and to the master through a request and grant pair. When nothing asks for the bus, the CPU keeps it. A master request raises hold. The master gets its grant only once the CPU has acknowledged.

The block also handles one coherency case. While the master owns the bus it may start a snoop of the CPU cache with a one-cycle strobe. If the CPU reports a hit on a dirty line within a fixed window after that strobe, the arbiter withdraws the grant and drops hold. This lets the CPU run its write-back. When the CPU's address strobe for that write-back is seen, hold is raised again at once, so no other CPU cycle can follow. After the CPU signals that the write-back is done and acknowledges hold again, the master is re-granted.

The block has six states. CPU_OWNS is the reset and idle state. HOLD_PENDING waits for the acknowledge. MASTER_OWNS is the granted state. WB_RELEASE has hold dropped for the write-back. WB_ACTIVE has hold raised again while the write-back runs. REGRANT waits for the acknowledge before the master resumes. Transitions are taken on the clock edge. Both outputs are decoded from the state alone.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A synchronous active-high reset puts the arbiter in CPU_OWNS. In the cycle after it, hold_req and m_grant are both 0.
- R2: In CPU_OWNS with m_req low, hold_req and m_grant stay 0. When m_req is sampled high in CPU_OWNS, the arbiter moves to HOLD_PENDING and hold_req is 1 from the next cycle, with m_grant still 0.
- R3: m_grant is 1 only in MASTER_OWNS, and it is never 1 while hold_req is 0. It rises only on the edge after hold_ack is sampled high, whether coming from HOLD_PENDING or from REGRANT.
- R4: When m_req is sampled low in HOLD_PENDING, or in MASTER_OWNS with no write-back triggered, the arbiter returns to CPU_OWNS. hold_req and m_grant are 0 from the next cycle.
- R5: When snoop_start is sampled high in MASTER_OWNS, a window of SNOOP_WIN following clock edges opens. If hit_dirty is sampled high on any of those edges, the arbiter takes WB_RELEASE, and m_grant and hold_req are 0 from the next cycle. This has priority over a low m_req.
- R6: hit_dirty sampled outside a window has no effect, and the master keeps its grant. This covers the same edge as snoop_start, the edge after the window closes, and hit_dirty with no snoop at all.
- R7: snoop_start sampled outside MASTER_OWNS opens no window. A later hit_dirty in MASTER_OWNS then causes no release.
- R8: In WB_RELEASE, hold_req stays 0 until cpu_strobe is sampled high. The arbiter then takes WB_ACTIVE, with hold_req 1 and m_grant 0 from the next cycle. A low m_req does not leave WB_RELEASE.
- R9: In WB_ACTIVE, m_grant stays 0 and hold_req stays 1 until cpu_done is sampled high. The arbiter then takes REGRANT.
- R10: In REGRANT, hold_req stays 1 and m_grant stays 0 until hold_ack is sampled high, and then MASTER_OWNS follows. If m_req is sampled low in REGRANT, the arbiter returns to CPU_OWNS instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| m_req | input | 1 | Master asks for the bus |
| m_grant | output | 1 | Master owns the bus |
| hold_req | output | 1 | Hold request to the CPU |
| hold_ack | input | 1 | CPU has released the bus |
| snoop_start | input | 1 | Master starts a cache snoop (one-cycle strobe) |
| hit_dirty | input | 1 | CPU reports a snoop hit on a dirty line |
| cpu_strobe | input | 1 | CPU address strobe, start of its write-back |
| cpu_done | input | 1 | CPU write-back has completed |

## Verification
The bench builds the arbiter with SNOOP_WIN set to 3. With that value, a vector table can place hit_dirty on each edge inside the window, on the edge of the snoop strobe itself, and on the first edge after the window closes, all in a few cycles per row. A small CPU model in the bench returns the acknowledge one cycle after hold. The model withholds the acknowledge while its write-back is running, which makes the wait in REGRANT visible. Directed tests then cover reset during a grant, request withdrawal in each state that allows it, and snoops outside the granted state.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [2:0] {
        CPU_OWNS     = 3'd0,
        HOLD_PENDING = 3'd1,
        MASTER_OWNS  = 3'd2,
        WB_RELEASE   = 3'd3,
        WB_ACTIVE    = 3'd4,
        REGRANT      = 3'd5
    } arb_state_e;

endpackage

// File: rtl/snoop_window.sv
module snoop_window #(
    parameter int SNOOP_WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic clear,
    output logic open
);
    localparam int CW = $clog2(SNOOP_WIN + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            remain <= '0;
        end else if (arm) begin
            remain <= CW'(SNOOP_WIN);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign open = (remain != '0);

endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       m_req,
    input  logic       hold_ack,
    input  logic       snoop_hit,
    input  logic       cpu_strobe,
    input  logic       cpu_done,
    output arb_state_e state,
    output logic       hold_req,
    output logic       m_grant,
    output logic       granted
);
    arb_state_e next;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CPU_OWNS;
        end else begin
            state <= next;
        end
    end

    always_comb begin
        next = state;
        unique case (state)
            CPU_OWNS:     if (m_req) next = HOLD_PENDING;
            HOLD_PENDING: begin
                if (!m_req)        next = CPU_OWNS;
                else if (hold_ack) next = MASTER_OWNS;
            end
            MASTER_OWNS: begin
                if (snoop_hit)     next = WB_RELEASE;
                else if (!m_req)   next = CPU_OWNS;
            end
            WB_RELEASE:   if (cpu_strobe) next = WB_ACTIVE;
            WB_ACTIVE:    if (cpu_done)   next = REGRANT;
            REGRANT: begin
                if (!m_req)        next = CPU_OWNS;
                else if (hold_ack) next = MASTER_OWNS;
            end
            default:      next = CPU_OWNS;
        endcase
    end

    always_comb begin
        hold_req = 1'b0;
        m_grant  = 1'b0;
        unique case (state)
            CPU_OWNS:     ;
            HOLD_PENDING: hold_req = 1'b1;
            MASTER_OWNS: begin
                hold_req = 1'b1;
                m_grant  = 1'b1;
            end
            WB_RELEASE:   ;
            WB_ACTIVE:    hold_req = 1'b1;
            REGRANT:      hold_req = 1'b1;
            default:      ;
        endcase
        granted = m_grant;
    end

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import arb_pkg::*;
#(
    parameter int SNOOP_WIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic m_req,
    output logic m_grant,
    output logic hold_req,
    input  logic hold_ack,
    input  logic snoop_start,
    input  logic hit_dirty,
    input  logic cpu_strobe,
    input  logic cpu_done
);
    arb_state_e state;
    logic       granted;
    logic       win_open;
    logic       snoop_hit;

    snoop_window #(.SNOOP_WIN(SNOOP_WIN)) u_window (
        .clk   (clk),
        .rst   (rst),
        .arm   (snoop_start & granted),
        .clear (~granted),
        .open  (win_open)
    );

    assign snoop_hit = hit_dirty & win_open;

    arb_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .m_req      (m_req),
        .hold_ack   (hold_ack),
        .snoop_hit  (snoop_hit),
        .cpu_strobe (cpu_strobe),
        .cpu_done   (cpu_done),
        .state      (state),
        .hold_req   (hold_req),
        .m_grant    (m_grant),
        .granted    (granted)
    );

endmodule

// File: rtl/bus_hold_arbiter_checker.sv
module bus_hold_arbiter_checker
    import arb_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       m_req,
    input logic       m_grant,
    input logic       hold_req,
    input logic       hold_ack,
    input logic       hit_dirty,
    input logic       win_open,
    input logic       cpu_strobe,
    input logic       cpu_done,
    input arb_state_e state
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!hold_req && !m_grant));

    a_r2_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (state == CPU_OWNS && !m_req) |=> (!hold_req && !m_grant));

    a_r3_grant_under_hold: assert property (@(posedge clk) disable iff (rst)
        m_grant |-> hold_req);

    a_r3_grant_after_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(m_grant) |-> $past(hold_ack));

    a_r5_hit_releases: assert property (@(posedge clk) disable iff (rst)
        (m_grant && hit_dirty && win_open) |=> (!hold_req && !m_grant));

    a_r8_hold_back_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (state == WB_RELEASE && cpu_strobe) |=> (hold_req && !m_grant));

    a_r8_hold_low_waiting: assert property (@(posedge clk) disable iff (rst)
        (state == WB_RELEASE && !cpu_strobe) |=> (!hold_req && !m_grant));

    a_r9_no_grant_in_wb: assert property (@(posedge clk) disable iff (rst)
        (state == WB_ACTIVE && !cpu_done) |=> (hold_req && !m_grant));

    a_r10_wait_ack: assert property (@(posedge clk) disable iff (rst)
        (state == REGRANT && m_req && !hold_ack) |=> (hold_req && !m_grant));

endmodule

bind bus_hold_arbiter bus_hold_arbiter_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .m_req      (m_req),
    .m_grant    (m_grant),
    .hold_req   (hold_req),
    .hold_ack   (hold_ack),
    .hit_dirty  (hit_dirty),
    .win_open   (win_open),
    .cpu_strobe (cpu_strobe),
    .cpu_done   (cpu_done),
    .state      (state)
);

// File: tb/bus_hold_arbiter_bench.sv
module bus_hold_arbiter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 3;
    localparam int ROWS = 7;
    // hit_dirty edge offset after the snoop edge (-1 = never), expected release
    localparam int ROW_DLY [ROWS] = '{1, 2, 3, 4, 0, -1, 2};
    localparam bit ROW_WB  [ROWS] = '{1, 1, 1, 0, 0, 0, 1};

    logic clk = 1'b0;
    logic rst, m_req, m_grant, hold_req, hold_ack;
    logic snoop_start, hit_dirty, cpu_strobe, cpu_done, cpu_busy;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // CPU model: acknowledges hold one cycle later unless writing back
    always_ff @(posedge clk) begin
        if (rst) hold_ack <= 1'b0;
        else     hold_ack <= hold_req & ~cpu_busy;
    end

    bus_hold_arbiter #(.SNOOP_WIN(WIN)) u_bus_hold_arbiter (
        .clk(clk), .rst(rst), .m_req(m_req), .m_grant(m_grant),
        .hold_req(hold_req), .hold_ack(hold_ack), .snoop_start(snoop_start),
        .hit_dirty(hit_dirty), .cpu_strobe(cpu_strobe), .cpu_done(cpu_done)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic exp_hold, input logic exp_grant);
        checks++;
        if (hold_req !== exp_hold || m_grant !== exp_grant) begin
            errors++;
            $display("FAIL %s: hold_req/m_grant actual %b%b expected %b%b",
                     req, hold_req, m_grant, exp_hold, exp_grant);
        end
    endtask

    task automatic acquire();
        m_req = 1'b1;
        tick();
        expect_out("R2 request raises hold", 1'b1, 1'b0);
        tick(2);
        expect_out("R3 grant after ack", 1'b1, 1'b1);
    endtask

    task automatic writeback(input string req);
        cpu_busy = 1'b1;
        tick(2);
        expect_out({req, " R8 hold low until strobe"}, 1'b0, 1'b0);
        cpu_strobe = 1'b1;
        tick();
        cpu_strobe = 1'b0;
        expect_out({req, " R8 hold back on strobe"}, 1'b1, 1'b0);
        tick(2);
        expect_out({req, " R9 no grant during write-back"}, 1'b1, 1'b0);
        cpu_done = 1'b1;
        tick();
        cpu_done = 1'b0;
        cpu_busy = 1'b0;
        expect_out({req, " R10 regrant waits"}, 1'b1, 1'b0);
        tick();
        expect_out({req, " R10 regrant waits for ack"}, 1'b1, 1'b0);
        tick();
        expect_out({req, " R10 master regranted"}, 1'b1, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; m_req = 1'b0; snoop_start = 1'b0; hit_dirty = 1'b0;
        cpu_strobe = 1'b0; cpu_done = 1'b0; cpu_busy = 1'b0;
        tick(3);
        rst = 1'b0;
        expect_out("R1 reset state", 1'b0, 1'b0);
        tick(4);
        expect_out("R2 idle keeps CPU owner", 1'b0, 1'b0);

        acquire();

        // Table of snoop rows
        for (int i = 0; i < ROWS; i++) begin
            tick(WIN + 2);
            expect_out("R3 master holds before snoop", 1'b1, 1'b1);
            snoop_start = 1'b1;
            if (ROW_DLY[i] == 0) hit_dirty = 1'b1;
            tick();
            snoop_start = 1'b0;
            hit_dirty = 1'b0;
            if (ROW_DLY[i] > 0) begin
                tick(ROW_DLY[i] - 1);
                hit_dirty = 1'b1;
                tick();
                hit_dirty = 1'b0;
            end else begin
                tick(WIN + 1);
            end
            if (ROW_WB[i]) begin
                expect_out("R5 hit in window releases", 1'b0, 1'b0);
                writeback("R5");
            end else begin
                expect_out("R6 hit outside window ignored", 1'b1, 1'b1);
            end
        end

        // hit_dirty with no snoop at all
        tick(WIN + 2);
        hit_dirty = 1'b1;
        tick();
        hit_dirty = 1'b0;
        expect_out("R6 hit without snoop ignored", 1'b1, 1'b1);

        // withdrawal in MASTER_OWNS
        m_req = 1'b0;
        tick();
        expect_out("R4 release from master", 1'b0, 1'b0);

        // snoop outside grant opens no window
        tick(2);
        snoop_start = 1'b1;
        tick();
        snoop_start = 1'b0;
        expect_out("R7 snoop while CPU owns ignored", 1'b0, 1'b0);
        acquire();
        hit_dirty = 1'b1;
        tick();
        hit_dirty = 1'b0;
        expect_out("R7 no window from stale snoop", 1'b1, 1'b1);

        // hit with request dropped: release wins, write-back still runs
        snoop_start = 1'b1;
        tick();
        snoop_start = 1'b0;
        hit_dirty = 1'b1;
        m_req = 1'b0;
        tick();
        hit_dirty = 1'b0;
        expect_out("R5 hit beats withdrawal", 1'b0, 1'b0);
        cpu_busy = 1'b1;
        tick(3);
        expect_out("R8 low request stays in release", 1'b0, 1'b0);
        cpu_strobe = 1'b1;
        tick();
        cpu_strobe = 1'b0;
        expect_out("R8 hold back on strobe", 1'b1, 1'b0);
        cpu_done = 1'b1;
        tick();
        cpu_done = 1'b0;
        cpu_busy = 1'b0;
        expect_out("R9 done leads to regrant", 1'b1, 1'b0);
        tick();
        expect_out("R10 low request returns to CPU", 1'b0, 1'b0);

        // withdrawal in HOLD_PENDING
        tick(2);
        m_req = 1'b1;
        tick();
        expect_out("R2 pending", 1'b1, 1'b0);
        m_req = 1'b0;
        tick();
        expect_out("R4 release from pending", 1'b0, 1'b0);

        // reset during a grant
        tick(2);
        acquire();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        m_req = 1'b0;
        expect_out("R1 reset during grant", 1'b0, 1'b0);
        tick(2);
        expect_out("R1 stays idle after reset", 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule